// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the locked configuration front end of a legacy Super I/O device. It sits on a byte-wide I/O bus and answers at two adjacent addresses. The lower address is an index port and the next one is a data port. After reset the configuration space is hidden. Data-port writes do nothing, and reads of either port return 0xFF.

The host opens the space by writing a fixed four-byte key to the index port. It then writes a register number to the index port and moves bytes through the data port. Global registers hold a logical device number, the chip identity word and the chip revision. A bank of device registers follows the logical device number. Only the GPIO device (number 0x07) is implemented. It holds a 16-bit base address for the GPIO data ports, plus per-group output-enable and simple-mode bytes. The block drives all of these values out as static configuration to the GPIO port logic. A write to control register 0x02 with bit 1 set closes the space again.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the configuration space is closed (cfg_open low), io_rdack is low, the latched index is 0x00, and gpio_base, gpio_oe and gpio_simple are all zero.
- R2: Writing 0x87, 0x01, 0x55, 0x55 in that order to the index port (address INDEX_PORT, default 0x2E) raises cfg_open on the clock edge of the fourth write.
- R3: In the key sequence, a byte that is not the expected one restarts matching. That byte is itself compared against the first key byte 0x87, so 0x87 counts as a fresh start.
- R4: While closed, data-port writes change no register, index-port writes do not change the latched index, and reads of either port return 0xFF.
- R5: A read strobe at the index port or at the data port (INDEX_PORT+1) is answered with a one-cycle io_rdack pulse and the byte on io_rdata in the next cycle. Accesses at any other address produce no acknowledge and change no state.
- R6: Register 0x20 reads CHIP_ID[15:8], 0x21 reads CHIP_ID[7:0] and 0x22 reads {4'h0, CHIP_REV}. Writes to these three registers are ignored.
- R7: Register 0x07 is a read/write 8-bit logical device number. A read of the index port while open returns the latched index.
- R8: With logical device 0x07 selected, register 0x62 is the high byte and 0x63 the low byte of gpio_base. With any other device selected, bank registers read 0x00 and ignore writes.
- R9: In the GPIO bank, register 0xC8+g is the output-enable byte of group g (gpio_oe[8g+7:8g]) and 0xC0+g is the simple-mode byte (gpio_simple[8g+7:8g]), for g < GPIO_GROUPS. Indices for groups at or above GPIO_GROUPS read 0x00 and ignore writes.
- R10: A data-port write to register 0x02 with bit 1 set lowers cfg_open on that clock edge, and with bit 1 clear it has no effect. Register values survive the lock, and reopening needs the full key again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Single-cycle read strobe |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte, valid with io_rdack |
| io_rdack | output | 1 | Read acknowledge, one cycle after an accepted read |
| cfg_open | output | 1 | Configuration space is unlocked |
| gpio_base | output | 16 | GPIO data-port base address |
| gpio_oe | output | 8*GPIO_GROUPS | Per-line output enables |
| gpio_simple | output | 8*GPIO_GROUPS | Per-line simple-mode selects |

## Verification
A wrong key-matcher position shows up at cfg_open. The port either opens one write early or late, or it never opens after a restarted sequence. All of this is visible on the edge of the offending index write. A corrupted latched index or device number makes the next data-port read return the wrong byte on the following cycle, or makes a write land on gpio_base, gpio_oe or gpio_simple, where it shows at once. A stuck lock state shows as 0xFF read data, or as a static output that moves while the space should be closed.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int KEY_LEN = 4;

  // global configuration registers
  localparam logic [7:0] REG_CTRL    = 8'h02;
  localparam logic [7:0] REG_LDN     = 8'h07;
  localparam logic [7:0] REG_ID_HI   = 8'h20;
  localparam logic [7:0] REG_ID_LO   = 8'h21;
  localparam logic [7:0] REG_REV     = 8'h22;

  // GPIO logical device and its bank
  localparam logic [7:0] LDN_GPIO    = 8'h07;
  localparam logic [7:0] REG_BASE_HI = 8'h62;
  localparam logic [7:0] REG_BASE_LO = 8'h63;
  localparam logic [7:0] REG_SIMPLE0 = 8'hC0;
  localparam logic [7:0] REG_OE0     = 8'hC8;

  localparam int LOCK_BIT = 1;

  // unlock key, one byte per position
  function automatic logic [7:0] key_byte(input int unsigned pos);
    case (pos)
      0:       key_byte = 8'h87;
      1:       key_byte = 8'h01;
      default: key_byte = 8'h55;
    endcase
  endfunction

endpackage

// File: rtl/sio_rst_sync.sv
module sio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/sio_key_matcher.sv
module sio_key_matcher
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  input  logic       relock,
  output logic       open
);

  localparam int PW = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
  localparam logic [PW-1:0] LAST_POS = PW'(KEY_LEN - 1);

  logic [PW-1:0] pos_q, pos_d;
  logic          open_q, open_d;
  logic          step_en;

  assign step_en = relock | (byte_vld & ~open_q);

  always_comb begin
    pos_d  = pos_q;
    open_d = open_q;
    if (relock) begin
      open_d = 1'b0;
      pos_d  = '0;
    end else if (byte_vld && !open_q) begin
      if (byte_in == key_byte(int'(pos_q))) begin
        if (pos_q == LAST_POS) begin
          open_d = 1'b1;
          pos_d  = '0;
        end else begin
          pos_d = pos_q + PW'(1);
        end
      end else if (byte_in == key_byte(0)) begin
        pos_d = PW'(1);
      end else begin
        pos_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      open_q <= 1'b0;
    end else if (step_en) begin
      pos_q  <= pos_d;
      open_q <= open_d;
    end
  end

  assign open = open_q;

endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID     = 16'h8728,
  parameter logic [3:0]  CHIP_REV    = 4'h3,
  parameter int          GPIO_GROUPS = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     open,
  input  logic                     idx_wr,
  input  logic                     data_wr,
  input  logic [7:0]               wdata,
  output logic [7:0]               idx,
  output logic [7:0]               cfg_rd,
  output logic                     relock,
  output logic [15:0]              gpio_base,
  output logic [8*GPIO_GROUPS-1:0] gpio_oe,
  output logic [8*GPIO_GROUPS-1:0] gpio_simple
);

  logic [7:0] idx_q;
  logic [7:0] ldn_q;
  logic [7:0] base_hi_q, base_lo_q;
  logic [7:0] oe_q     [GPIO_GROUPS];
  logic [7:0] simple_q [GPIO_GROUPS];

  logic idx_en, ldn_en, base_hi_en, base_lo_en, gpio_sel, bank_wr;

  assign gpio_sel   = (ldn_q == LDN_GPIO);
  assign idx_en     = idx_wr & open;
  assign ldn_en     = data_wr & open & (idx_q == REG_LDN);
  assign bank_wr    = data_wr & open & gpio_sel;
  assign base_hi_en = bank_wr & (idx_q == REG_BASE_HI);
  assign base_lo_en = bank_wr & (idx_q == REG_BASE_LO);
  assign relock     = data_wr & open & (idx_q == REG_CTRL) & wdata[LOCK_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= 8'h00;
    else if (idx_en) idx_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ldn_q <= 8'h00;
    else if (ldn_en) ldn_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          base_hi_q <= 8'h00;
    else if (base_hi_en) base_hi_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          base_lo_q <= 8'h00;
    else if (base_lo_en) base_lo_q <= wdata;
  end

  for (genvar g = 0; g < GPIO_GROUPS; g++) begin : g_group
    logic oe_en, simple_en;
    assign oe_en     = bank_wr & (idx_q == REG_OE0 + 8'(g));
    assign simple_en = bank_wr & (idx_q == REG_SIMPLE0 + 8'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     oe_q[g] <= 8'h00;
      else if (oe_en) oe_q[g] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         simple_q[g] <= 8'h00;
      else if (simple_en) simple_q[g] <= wdata;
    end

    assign gpio_oe[8*g +: 8]     = oe_q[g];
    assign gpio_simple[8*g +: 8] = simple_q[g];
  end

  always_comb begin
    cfg_rd = 8'h00;
    case (idx_q)
      REG_LDN:   cfg_rd = ldn_q;
      REG_ID_HI: cfg_rd = CHIP_ID[15:8];
      REG_ID_LO: cfg_rd = CHIP_ID[7:0];
      REG_REV:   cfg_rd = {4'h0, CHIP_REV};
      default: begin
        if (gpio_sel) begin
          if (idx_q == REG_BASE_HI) cfg_rd = base_hi_q;
          if (idx_q == REG_BASE_LO) cfg_rd = base_lo_q;
          for (int g = 0; g < GPIO_GROUPS; g++) begin
            if (idx_q == REG_OE0 + 8'(g))     cfg_rd = oe_q[g];
            if (idx_q == REG_SIMPLE0 + 8'(g)) cfg_rd = simple_q[g];
          end
        end
      end
    endcase
  end

  assign idx       = idx_q;
  assign gpio_base = {base_hi_q, base_lo_q};

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT  = 16'h002E,
  parameter logic [15:0]       CHIP_ID     = 16'h8728,
  parameter logic [3:0]        CHIP_REV    = 4'h3,
  parameter int                GPIO_GROUPS = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        io_addr,
  input  logic                     io_wr,
  input  logic                     io_rd,
  input  logic [7:0]               io_wdata,
  output logic [7:0]               io_rdata,
  output logic                     io_rdack,
  output logic                     cfg_open,
  output logic [15:0]              gpio_base,
  output logic [8*GPIO_GROUPS-1:0] gpio_oe,
  output logic [8*GPIO_GROUPS-1:0] gpio_simple
);

  localparam logic [ADDR_W-1:0] DATA_PORT = INDEX_PORT + ADDR_W'(1);

  if (GPIO_GROUPS < 1 || GPIO_GROUPS > 8) begin : g_bad_groups
    $error("GPIO_GROUPS must lie between 1 and 8");
  end

  logic       rst_n_sync;
  logic       hit_idx, hit_dat, rd_hit;
  logic       relock;
  logic [7:0] idx, cfg_rd, rd_val;
  logic [7:0] rdata_q;
  logic       rdack_q;

  assign hit_idx = (io_addr == INDEX_PORT);
  assign hit_dat = (io_addr == DATA_PORT);
  assign rd_hit  = io_rd & (hit_idx | hit_dat);

  sio_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  sio_key_matcher u_key (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .byte_vld (io_wr & hit_idx),
    .byte_in  (io_wdata),
    .relock   (relock),
    .open     (cfg_open)
  );

  sio_cfg_regs #(
    .CHIP_ID     (CHIP_ID),
    .CHIP_REV    (CHIP_REV),
    .GPIO_GROUPS (GPIO_GROUPS)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .open        (cfg_open),
    .idx_wr      (io_wr & hit_idx),
    .data_wr     (io_wr & hit_dat),
    .wdata       (io_wdata),
    .idx         (idx),
    .cfg_rd      (cfg_rd),
    .relock      (relock),
    .gpio_base   (gpio_base),
    .gpio_oe     (gpio_oe),
    .gpio_simple (gpio_simple)
  );

  always_comb begin
    if (!cfg_open)    rd_val = 8'hFF;
    else if (hit_idx) rd_val = idx;
    else              rd_val = cfg_rd;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)  rdata_q <= 8'h00;
    else if (rd_hit)  rdata_q <= rd_val;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) rdack_q <= 1'b0;
    else             rdack_q <= rd_hit;
  end

  assign io_rdata = rdata_q;
  assign io_rdack = rdack_q;

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h002E
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              io_rdack,
  input logic              cfg_open,
  input logic [15:0]       gpio_base
);

  logic at_idx, at_dat;
  assign at_idx = (io_addr == INDEX_PORT);
  assign at_dat = (io_addr == INDEX_PORT + ADDR_W'(1));

  AST_RESET_CLOSED: assert property (@(posedge clk) !rst_n |-> !cfg_open && !io_rdack); // R1

  AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(io_wr && at_idx && io_wdata == 8'h55)); // R2

  AST_CLOSED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && (at_idx || at_dat) && !cfg_open) |=> (io_rdata == 8'hFF)); // R4

  AST_CLOSED_BASE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(gpio_base)); // R4

  AST_ACK_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && (at_idx || at_dat)) |=> io_rdack); // R5

  AST_NO_ACK_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && (at_idx || at_dat)) |=> !io_rdack); // R5

  AST_CLOSE_ON_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_open) |-> $past(io_wr && at_dat && io_wdata[1])); // R10

endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .ADDR_W     (ADDR_W),
  .INDEX_PORT (INDEX_PORT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .io_addr   (io_addr),
  .io_wr     (io_wr),
  .io_rd     (io_rd),
  .io_wdata  (io_wdata),
  .io_rdata  (io_rdata),
  .io_rdack  (io_rdack),
  .cfg_open  (cfg_open),
  .gpio_base (gpio_base)
);

// File: tb/test_sio_cfg_port.sv
`timescale 1ns/1ps
module test_sio_cfg_port;

  localparam int          GG   = 5;
  localparam logic [15:0] IDX  = 16'h002E;
  localparam logic [15:0] DAT  = 16'h002F;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   io_addr = 16'h0;
  logic          io_wr = 1'b0;
  logic          io_rd = 1'b0;
  logic [7:0]    io_wdata = 8'h0;
  logic [7:0]    io_rdata;
  logic          io_rdack;
  logic          cfg_open;
  logic [15:0]   gpio_base;
  logic [8*GG-1:0] gpio_oe;
  logic [8*GG-1:0] gpio_simple;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  sio_cfg_port #(.GPIO_GROUPS(GG)) i_sio_cfg_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rdack(io_rdack),
    .cfg_open(cfg_open), .gpio_base(gpio_base), .gpio_oe(gpio_oe),
    .gpio_simple(gpio_simple)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read bytes as acknowledges come back
  always @(negedge clk) begin
    if (io_rdack) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R5: actual unexpected ack data %0h expected no ack", io_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 64'(io_rdata), 64'(e));
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    io_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic key();
    wr(IDX, 8'h87); wr(IDX, 8'h01); wr(IDX, 8'h55); wr(IDX, 8'h55);
  endtask

  task automatic reg_wr(input logic [7:0] r, input logic [7:0] d);
    wr(IDX, r); wr(DAT, d);
  endtask

  task automatic reg_rd(input logic [7:0] r, input logic [7:0] e, input string tag);
    wr(IDX, r); rd(DAT, e, tag);
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 open", 64'(cfg_open), 64'd0);
    check("R1 ack", 64'(io_rdack), 64'd0);
    check("R1 base", 64'(gpio_base), 64'd0);
    check("R1 oe", 64'(gpio_oe), 64'd0);
    check("R1 simple", 64'(gpio_simple), 64'd0);

    // R4 closed behaviour
    rd(DAT, 8'hFF, "R4 closed data read");
    rd(IDX, 8'hFF, "R4 closed index read");
    wr(IDX, 8'h62);
    wr(DAT, 8'h12);
    check("R4 base unchanged", 64'(gpio_base), 64'd0);

    // R2 unlock
    wr(IDX, 8'h87); wr(IDX, 8'h01); wr(IDX, 8'h55);
    check("R2 not yet open", 64'(cfg_open), 64'd0);
    wr(IDX, 8'h55);
    check("R2 open", 64'(cfg_open), 64'd1);
    rd(IDX, 8'h00, "R4 index kept while closed");

    // R6 identity
    reg_rd(8'h20, 8'h87, "R6 id high");
    reg_rd(8'h21, 8'h28, "R6 id low");
    reg_rd(8'h22, 8'h03, "R6 revision");
    reg_wr(8'h20, 8'h55);
    reg_rd(8'h20, 8'h87, "R6 id write ignored");

    // R7 device number and index readback
    reg_wr(8'h07, 8'h05);
    reg_rd(8'h07, 8'h05, "R7 ldn readback");
    rd(IDX, 8'h07, "R7 index readback");

    // R8 other device: bank hidden
    reg_wr(8'h62, 8'hAB);
    reg_rd(8'h62, 8'h00, "R8 other ldn reads zero");
    check("R8 other ldn write ignored", 64'(gpio_base), 64'd0);

    // R8 GPIO device
    reg_wr(8'h07, 8'h07);
    reg_wr(8'h62, 8'h0A);
    reg_wr(8'h63, 8'h30);
    check("R8 base", 64'(gpio_base), 64'h0A30);
    reg_rd(8'h62, 8'h0A, "R8 base high read");
    reg_rd(8'h63, 8'h30, "R8 base low read");

    // R9 groups
    reg_wr(8'hC8, 8'hF0);
    reg_wr(8'hCC, 8'h81);
    reg_wr(8'hC0, 8'h3C);
    reg_wr(8'hCD, 8'h77);
    check("R9 oe", 64'(gpio_oe), 64'h81_00_00_00_F0);
    check("R9 simple", 64'(gpio_simple), 64'h3C);
    reg_rd(8'hCC, 8'h81, "R9 oe top group read");
    reg_rd(8'hCD, 8'h00, "R9 group beyond range");

    // R5 foreign address
    wr(16'h004E, 8'h02);
    @(negedge clk); io_addr = 16'h004E; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0;
    check("R5 no ack on miss", 64'(io_rdack), 64'd0);
    check("R5 miss no effect", 64'(cfg_open), 64'd1);

    // R10 lock
    reg_wr(8'h02, 8'h00);
    check("R10 bit clear keeps open", 64'(cfg_open), 64'd1);
    wr(DAT, 8'h02);
    check("R10 locked", 64'(cfg_open), 64'd0);
    rd(DAT, 8'hFF, "R10 locked read");
    wr(DAT, 8'h99);
    check("R10 base retained", 64'(gpio_base), 64'h0A30);

    // R3 restart rules
    wr(IDX, 8'h87); wr(IDX, 8'h01); wr(IDX, 8'h87);
    wr(IDX, 8'h01); wr(IDX, 8'h55); wr(IDX, 8'h55);
    check("R3 restart on 87", 64'(cfg_open), 64'd1);
    reg_wr(8'h02, 8'h02);
    check("R10 relock", 64'(cfg_open), 64'd0);
    wr(IDX, 8'h87); wr(IDX, 8'h01); wr(IDX, 8'h55); wr(IDX, 8'h00); wr(IDX, 8'h55);
    check("R3 broken key stays closed", 64'(cfg_open), 64'd0);
    wr(IDX, 8'h87); wr(IDX, 8'h87); wr(IDX, 8'h01); wr(IDX, 8'h55); wr(IDX, 8'h55);
    check("R3 repeated first byte", 64'(cfg_open), 64'd1);
    reg_rd(8'h63, 8'h30, "R10 value survives relock");

    repeat (3) @(negedge clk);
    check("R5 all reads acknowledged", 64'(exp_q.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule